// File: doc/BRIEF.md
# Codec Control Instruction Port

This block is the serial command front end of a telephony codec. A host frames each instruction with an active-low select line and clocks it in one bit at a time on a dedicated control clock. The first byte of an instruction always carries the requested power state, a register address, a direction bit and a length bit. A two-byte write stores its second byte in the addressed register. A two-byte read returns the register on a separate data output while the host clocks a dummy second byte. A one-byte instruction changes only the power state.

The block holds a register file of sixteen 8-bit entries and a power-down flag. The flag is set by reset and follows bit 7 of every first byte. The port keeps accepting reads and writes while the codec is powered down. The rest of the codec sees every register through a parallel lookup port and gets a one-cycle notice of each write.

Top module: `ctl_serial_port`

## Requirements
- R1: While reset is asserted, `pwr_down` is 1, `sdo_oe` and `wr_stb` are 0, and every register reads 0 through `rf_addr`/`rf_data`.
- R2: While `sel_n` is low, serial input bits are sampled MSB first on rising clock edges. On the edge that completes the first byte of any instruction, `pwr_down` takes that byte's bit 7 (1 = power down, 0 = power up). `pwr_down` changes at no other time.
- R3: A first byte with bit 2 = 0 and bit 1 = 1 is a two-byte write. On the edge that completes the second byte, the register addressed by first-byte bits 6..3 takes the second byte. In the cycle after that edge, `wr_stb` is 1 for one cycle, with `wr_addr` and `wr_data` showing the address and value written.
- R4: A first byte with bit 2 = 1 and bit 1 = 1 is a two-byte read. During the second byte, `sdo_oe` is 1 and `sdo` presents the addressed register MSB first, with a new bit on each falling edge, so the host can sample on rising edges. No register changes and `wr_stb` stays 0.
- R5: A first byte with bit 1 = 0 is a complete one-byte instruction whatever its bit 2. It changes only the power state, enables no output, and the next byte is taken as a new first byte.
- R6: Raising `sel_n` before a byte is complete discards the partial byte. A partial first byte leaves the power state unchanged. A partial second byte leaves every register unchanged. The next byte after `sel_n` falls again is a first byte.
- R7: `sdo_oe` is 0 whenever `sel_n` is high and outside the second byte of a read.
- R8: While powered down, writes and reads work as in R3 and R4, and registers keep their contents except where rewritten.
- R9: Bit 0 of the first byte has no effect on any output or register.
- R10: Several instructions may follow one another in a single low period of `sel_n`, and each is decoded as if it were framed on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ctl | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low instruction framing select |
| sdi | input | 1 | Serial instruction data in |
| sdo | output | 1 | Serial read data out (0 when not enabled) |
| sdo_oe | output | 1 | Output driver enable for `sdo`; low means high impedance |
| pwr_down | output | 1 | Device power-down flag |
| wr_stb | output | 1 | One-cycle register write notice |
| wr_addr | output | 4 | Address of the last write |
| wr_data | output | 8 | Value of the last write |
| rf_addr | input | 4 | Parallel register lookup address |
| rf_data | output | 8 | Contents of register `rf_addr` |

## Verification
The bench sends the instruction forms in several arrangements: one-byte power commands (with the direction bit both clear and set), two-byte writes and reads framed alone, and mixed write/write/read chains in one select window. The chains separate correct byte-phase tracking from a decoder that only works right after a select edge. Aborts inside a first byte and inside a second byte show whether partial bytes leak into the power flag or the registers. Writes and reads made with the power bit set show that the port still works while powered down. A header with bit 0 set shows whether that bit is truly ignored. A behavioural model, compared on every clock, checks the power flag, driver enable, write notice and a sweeping register lookup.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  parameter int CMD_W  = 8;
  parameter int ADDR_W = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(CMD_W);
  localparam int PWR_POS  = CMD_W - 1;
  localparam int ADDR_LO  = CMD_W - 1 - ADDR_W;
  localparam int RD_POS   = 2;
  localparam int LEN_POS  = 1;

  typedef logic [CMD_W-1:0]  cmd_byte_t;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [CNT_W-1:0]  bit_cnt_t;

  typedef struct packed {
    logic      pwr;
    reg_addr_t addr;
    logic      rd;
    logic      two;
  } hdr_t;

  // Split a first byte into its fields; bit 0 carries no meaning.
  function automatic hdr_t hdr_decode(input cmd_byte_t b);
    hdr_t h;
    h.pwr  = b[PWR_POS];
    h.addr = b[ADDR_LO +: ADDR_W];
    h.rd   = b[RD_POS];
    h.two  = b[LEN_POS];
    return h;
  endfunction

  function automatic logic is_last_bit(input bit_cnt_t c);
    return c == bit_cnt_t'(CMD_W - 1);
  endfunction

  // Bit of a word sent at serial position c (MSB first).
  function automatic logic pick_tx_bit(input cmd_byte_t w, input bit_cnt_t c);
    cmd_byte_t s;
    s = w << c;
    return s[CMD_W-1];
  endfunction
endpackage

// File: rtl/ctl_rx_shift.sv
module ctl_rx_shift
  import ctl_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      sdi,
  output bit_cnt_t  bit_cnt,
  output logic      byte_done,
  output cmd_byte_t byte_val
);
  logic [CMD_W-2:0] sr;

  assign byte_val  = {sr, sdi};
  assign byte_done = !sel_n && is_last_bit(bit_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sr      <= '0;
    end else if (sel_n) begin
      bit_cnt <= '0;
    end else begin
      sr      <= byte_val[CMD_W-2:0];
      bit_cnt <= is_last_bit(bit_cnt) ? '0 : bit_cnt + bit_cnt_t'(1);
    end
  end

  // R6: a high select always restarts byte assembly
  assert_abort_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (bit_cnt == '0));
endmodule

// File: rtl/ctl_cmd_seq.sv
module ctl_cmd_seq
  import ctl_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      byte_done,
  input  cmd_byte_t byte_val,
  output logic      hdr_done,
  output logic      pwr_down,
  output logic      rd_phase,
  output logic      load_tx,
  output reg_addr_t load_addr,
  output logic      wr_now,
  output reg_addr_t wr_addr_now,
  output cmd_byte_t wr_data_now,
  output logic      wr_stb,
  output reg_addr_t wr_addr,
  output cmd_byte_t wr_data
);
  logic      in_body;
  logic      body_rd;
  reg_addr_t body_addr;
  hdr_t      hdr_in;

  assign hdr_in      = hdr_decode(byte_val);
  assign hdr_done    = byte_done && !in_body;
  assign load_tx     = hdr_done && hdr_in.two && hdr_in.rd;
  assign load_addr   = hdr_in.addr;
  assign rd_phase    = in_body && body_rd;
  assign wr_now      = byte_done && in_body && !body_rd;
  assign wr_addr_now = body_addr;
  assign wr_data_now = byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_body   <= 1'b0;
      body_rd   <= 1'b0;
      body_addr <= '0;
      pwr_down  <= 1'b1;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb <= wr_now;
      if (wr_now) begin
        wr_addr <= body_addr;
        wr_data <= byte_val;
      end
      if (sel_n) begin
        in_body <= 1'b0;
      end else if (hdr_done) begin
        pwr_down  <= hdr_in.pwr;
        in_body   <= hdr_in.two;
        body_addr <= hdr_in.addr;
        body_rd   <= hdr_in.rd;
      end else if (byte_done) begin
        in_body <= 1'b0;
      end
    end
  end

  // R2: the power flag moves only on a completed first byte
  assert_pwr_at_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_down) |-> $past(hdr_done));
  // R4: a read body never writes the register file
  assert_no_write_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !wr_now);
  // R7: the read phase ends once select goes high
  assert_body_ends_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !rd_phase);
  // R3: the write notice lasts one cycle
  assert_wstb_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import ctl_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  reg_addr_t waddr,
  input  cmd_byte_t wdata,
  input  reg_addr_t raddr_a,
  output cmd_byte_t rdata_a,
  input  reg_addr_t raddr_b,
  output cmd_byte_t rdata_b
);
  logic [NUM_REGS-1:0][CMD_W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (we && waddr == reg_addr_t'(i)) mem[i] <= wdata;
      end
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R8: contents hold unless a write is strobed
  assert_hold_without_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/ctl_tx_drive.sv
module ctl_tx_drive
  import ctl_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      load,
  input  cmd_byte_t load_word,
  input  logic      rd_phase,
  input  bit_cnt_t  bit_cnt,
  output logic      sdo,
  output logic      sdo_oe
);
  cmd_byte_t tx_word;
  logic      sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tx_word <= '0;
    else if (load) tx_word <= load_word;
  end

  // Launch on the falling edge so the host samples on the rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (rd_phase) sdo_q <= pick_tx_bit(tx_word, bit_cnt);
  end

  assign sdo_oe = rd_phase && !sel_n;
  assign sdo    = sdo_oe && sdo_q;

  // R4: the word being returned is not reloaded mid-read
  assert_tx_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !load);
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_port_pkg::*;
(
  input  logic              clk_ctl,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              pwr_down,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CMD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rf_addr,
  output logic [CMD_W-1:0]  rf_data
);
  bit_cnt_t  bit_cnt;
  logic      byte_done;
  cmd_byte_t byte_val;
  logic      hdr_done;
  logic      rd_phase;
  logic      load_tx;
  reg_addr_t load_addr;
  cmd_byte_t load_word;
  logic      wr_now;
  reg_addr_t wr_addr_now;
  cmd_byte_t wr_data_now;

  ctl_rx_shift u_rx (
    .clk(clk_ctl), .rst_n(rst_n), .sel_n(sel_n), .sdi(sdi),
    .bit_cnt(bit_cnt), .byte_done(byte_done), .byte_val(byte_val)
  );

  ctl_cmd_seq u_seq (
    .clk(clk_ctl), .rst_n(rst_n), .sel_n(sel_n),
    .byte_done(byte_done), .byte_val(byte_val),
    .hdr_done(hdr_done), .pwr_down(pwr_down), .rd_phase(rd_phase),
    .load_tx(load_tx), .load_addr(load_addr),
    .wr_now(wr_now), .wr_addr_now(wr_addr_now), .wr_data_now(wr_data_now),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ctl_reg_file u_rf (
    .clk(clk_ctl), .rst_n(rst_n),
    .we(wr_now), .waddr(wr_addr_now), .wdata(wr_data_now),
    .raddr_a(load_addr), .rdata_a(load_word),
    .raddr_b(rf_addr), .rdata_b(rf_data)
  );

  ctl_tx_drive u_tx (
    .clk(clk_ctl), .rst_n(rst_n), .sel_n(sel_n),
    .load(load_tx), .load_word(load_word),
    .rd_phase(rd_phase), .bit_cnt(bit_cnt),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // R5: a one-byte instruction never opens an output window
  assert_single_no_oe_R5: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (hdr_done && !byte_val[LEN_POS]) |=> !sdo_oe);
endmodule

// File: tb/ctl_serial_port_test.sv
module ctl_serial_port_test;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n, sel_n, sdi;
  logic       sdo, sdo_oe, pwr_down, wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rf_addr = 4'd0;
  logic [7:0] rf_data;

  ctl_serial_port uut (
    .clk_ctl(clk), .rst_n(rst_n), .sel_n(sel_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rf_addr(rf_addr), .rf_data(rf_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R1 reset";
  bit    done     = 0;

  // behavioural model state
  logic [7:0] mreg [16];
  bit         mpd = 1, exp_oe = 0, exp_wstb = 0, m_in_body = 0, m_rd = 0;
  logic [3:0] m_addr = 4'd0, last_wa = 4'd0;
  logic [7:0] last_wd = 8'd0, rx_cap = 8'd0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    #3;
    if (!done) begin
      check("pwr_down", {31'd0, pwr_down}, {31'd0, mpd});
      check("sdo_oe",   {31'd0, sdo_oe},   {31'd0, exp_oe});
      check("wr_stb",   {31'd0, wr_stb},   {31'd0, exp_wstb});
      if (exp_wstb) begin
        check("wr_addr", {28'd0, wr_addr}, {28'd0, last_wa});
        check("wr_data", {24'd0, wr_data}, {24'd0, last_wd});
      end
      check("register", {24'd0, rf_data}, {24'd0, mreg[rf_addr]});
      rf_addr <= rf_addr + 4'd1;
    end
  end

  task automatic drive_byte(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); #1 sel_n = 1'b0; sdi = b[7-i];
      #5 if (m_in_body && m_rd) rx_cap[7-i] = sdo;
      @(posedge clk); #1 exp_wstb = 0;
      if (i == 7) begin
        if (!m_in_body) begin
          mpd = b[7];
          if (b[1]) begin
            m_in_body = 1; m_addr = b[6:3]; m_rd = b[2]; exp_oe = b[2];
          end
        end else begin
          m_in_body = 0; exp_oe = 0;
          if (m_rd) check("read data", {24'd0, rx_cap}, {24'd0, mreg[m_addr]});
          else begin
            mreg[m_addr] = b; exp_wstb = 1; last_wa = m_addr; last_wd = b;
          end
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 sel_n = 1'b1; sdi = 1'b0; exp_oe = 0;
      @(posedge clk); #1 exp_wstb = 0; m_in_body = 0;
    end
  endtask

  task automatic instr2(input logic [7:0] h, input logic [7:0] d);
    drive_byte(h, 8);
    drive_byte(d, 8);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) mreg[a] = 8'd0;
    rst_n = 1'b0; sel_n = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    cur_tag = "R2 power-up one-byte";       drive_byte(8'h00, 8); idle(2);
    cur_tag = "R3 write reg5";              instr2(8'h2A, 8'hA5); idle(2);
    cur_tag = "R4 read reg5";               instr2(8'h2E, 8'hFF); idle(2);
    cur_tag = "R10 chained instructions";
    instr2(8'h1A, 8'h3C); instr2(8'h7A, 8'h81); instr2(8'h1E, 8'h00); idle(2);
    cur_tag = "R6 abort in second byte";    drive_byte(8'h2A, 8); drive_byte(8'h0F, 4); idle(3);
    cur_tag = "R6 abort in first byte";     drive_byte(8'h80, 5); idle(3);
    cur_tag = "R6 first byte after abort";  instr2(8'h7E, 8'h00); idle(2);
    cur_tag = "R8 write while powering down"; instr2(8'hBA, 8'h5A); idle(2);
    cur_tag = "R8 read while powered down"; instr2(8'hAE, 8'h00); idle(2);
    cur_tag = "R9 header bit0 set";         instr2(8'h4B, 8'hC3); idle(2);
    cur_tag = "R9 read with bit0 set";      instr2(8'h4F, 8'h00); idle(2);
    cur_tag = "R5 one-byte with rd bit";    drive_byte(8'h94, 8);
    cur_tag = "R5 next byte is header";     instr2(8'h12, 8'h77); idle(2);
    cur_tag = "R7 idle sweep";              idle(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule